// File: doc/BRIEF.md
# Periodic Sample Logger

The block takes a snapshot of a bank of parallel sample words at fixed instants and streams the words, one per clock, into an internal FIFO. A host processor drains that FIFO through a valid/ready read port. The instants come from a free-running interval timer. Its unit is a raw clock tick, a microsecond or a millisecond, and its period is a count of those units. The timer alone decides when a capture begins: a capture that is still writing when the next instant arrives is cut short, and the new snapshot replaces it.

A run control starts and stops logging. When the run control is low, the timer is held at its start phase and nothing is written. If a capture tries to write while the FIFO is full, the word is dropped and a sticky fault flag is raised. The fault stops the timer and the capture. The host can still read the words that are already buffered. The fault clears only when the clear input is pulsed while the run control is low.

Top module: `sample_logger`

## Requirements
- R1: After reset, rd_valid, fault and frame_start are all 0.
- R2: While run is 1 and fault is 0, frame_start pulses every period × D clock cycles. D is 1 for unit_sel 0 or 3, CLK_PER_US for unit_sel 1, and 1000 × CLK_PER_US for unit_sel 2. A period value of 0 acts as 1.
- R3: The cycle in which frame_start is 1 ends with a snapshot of smp_data. Beginning with the next clock, the snapshot is written one word per clock, starting with word 0 (bits DW-1:0) and rising in index. The host reads the words in the same order.
- R4: Every frame_start starts a new capture, whatever state the previous capture is in. When frames are S cycles apart, each capture writes min(NCH, S) words.
- R5: While run is 0, no frame_start pulse occurs and no word is written. The timer restarts its phase when run returns to 1.
- R6: A write attempted while the FIFO holds DEPTH words is dropped, even if a read happens in the same cycle. fault is 1 from the next cycle on. While fault is 1, no frame_start pulse occurs and no word is written.
- R7: fault stays 1 until fault_clr is 1 in a cycle where run is 0. fault_clr has no effect while run is 1.
- R8: rd_data is valid when rd_valid is 1, and a word is taken on a clock where rd_valid and rd_ready are both 1. While the port is stalled, rd_data holds its value. Reads keep working while fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Logging enable |
| unit_sel | input | 2 | Timer unit: 0 tick, 1 µs, 2 ms, 3 tick |
| period | input | PER_W | Interval in timer units |
| fault_clr | input | 1 | Fault clear, honoured only while run is 0 |
| smp_data | input | NCH*DW | Sample bank, word i at bits i*DW+DW-1 : i*DW |
| frame_start | output | 1 | One-cycle pulse at each capture instant |
| fault | output | 1 | Sticky overflow fault |
| rd_data | output | DW | FIFO head word |
| rd_valid | output | 1 | FIFO not empty |
| rd_ready | input | 1 | Host accepts the head word |

## Verification
The bench builds the block with NCH=4, DW=16, DEPTH=8 and CLK_PER_US=3. These values make a millisecond frame only 3000 cycles long, so the bench can measure the spacing in all three units. With two four-word captures the shallow FIFO fills exactly, which puts the overflow on the first word of the third capture. Frame spacings of 2 and 3 ticks, shorter than a four-word capture, exercise the cut-short captures.

// File: rtl/slog_pkg.sv
package slog_pkg;

    typedef enum logic [1:0] {
        UNIT_TICK  = 2'd0,
        UNIT_US    = 2'd1,
        UNIT_MS    = 2'd2,
        UNIT_TICK2 = 2'd3
    } unit_e;

    localparam int US_PER_MS = 1000;

endpackage

// File: rtl/slog_timebase.sv
module slog_timebase #(
    parameter int CLK_PER_US = 100,
    parameter int PER_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       unit_sel,
    input  logic [PER_W-1:0] period,
    output logic             frame
);
    localparam int MS_DIV = CLK_PER_US * slog_pkg::US_PER_MS;
    localparam int PW     = $clog2(MS_DIV + 1);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [PER_W-1:0] cnt;
        logic             frame;
    } tmr_t;

    tmr_t q, d;
    logic [PW-1:0]    lim_m1;
    logic [PER_W-1:0] last;
    logic             unit_pulse;

    always_comb begin
        case (unit_sel)
            slog_pkg::UNIT_US: lim_m1 = PW'(CLK_PER_US - 1);
            slog_pkg::UNIT_MS: lim_m1 = PW'(MS_DIV - 1);
            default:           lim_m1 = '0;
        endcase
        last       = (period == '0) ? '0 : period - 1'b1;
        unit_pulse = (q.pre == lim_m1);
        d          = q;
        d.frame    = 1'b0;
        if (!en) begin
            d = '0;
        end else begin
            d.pre = unit_pulse ? '0 : q.pre + 1'b1;
            if (unit_pulse) begin
                if (q.cnt >= last) begin
                    d.cnt   = '0;
                    d.frame = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame = q.frame;
endmodule

// File: rtl/slog_seq.sv
module slog_seq #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              frame,
    input  logic              full,
    input  logic              clr,
    input  logic [NCH*DW-1:0] smp,
    output logic              wr_en,
    output logic [DW-1:0]     wr_data,
    output logic              fault
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                   busy;
        logic [IW-1:0]          idx;
        logic [NCH-1:0][DW-1:0] shadow;
        logic                   fault;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_data = q.shadow[q.idx];
        if (q.busy && run && !q.fault) begin
            wr_en = 1'b1;
            if (full) begin
                d.fault = 1'b1;
                d.busy  = 1'b0;
            end else if (q.idx == IW'(NCH - 1)) begin
                d.busy = 1'b0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
        if (frame && run && !q.fault && !d.fault) begin
            d.busy   = 1'b1;
            d.idx    = '0;
            d.shadow = smp;
        end
        if (!run) begin
            d.busy = 1'b0;
            if (clr) d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fault = q.fault;
endmodule

// File: rtl/slog_fifo.sv
module slog_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          rd_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic push, pop;

    always_comb begin
        full     = (q.cnt == CW'(DEPTH));
        rd_valid = (q.cnt != '0);
        push     = wr_en && !full;
        pop      = rd_valid && rd_ready;
        d        = q;
        if (push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wp] <= wr_data;
    end

    assign rd_data = mem[q.rp];
endmodule

// File: rtl/sample_logger.sv
module sample_logger #(
    parameter int NCH        = 4,
    parameter int DW         = 16,
    parameter int DEPTH      = 64,
    parameter int CLK_PER_US = 100,
    parameter int PER_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        unit_sel,
    input  logic [PER_W-1:0]  period,
    input  logic              fault_clr,
    input  logic [NCH*DW-1:0] smp_data,
    output logic              frame_start,
    output logic              fault,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    input  logic              rd_ready
);
    logic          tmr_en;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          fifo_full;

    assign tmr_en = run && !fault;

    slog_timebase #(.CLK_PER_US(CLK_PER_US), .PER_W(PER_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .unit_sel(unit_sel),
        .period(period), .frame(frame_start)
    );

    slog_seq #(.NCH(NCH), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .frame(frame_start),
        .full(fifo_full), .clr(fault_clr), .smp(smp_data),
        .wr_en(wr_en), .wr_data(wr_data), .fault(fault)
    );

    slog_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(fifo_full), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready)
    );
endmodule

// File: rtl/slog_checker.sv
module slog_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          fault_clr,
    input logic          fault,
    input logic          frame_start,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          wr_en,
    input logic          fifo_full,
    input logic [DW-1:0] rd_data
);
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !wr_en) else $error("idle write"); // R5
    AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !frame_start) else $error("idle frame"); // R5
    AST_FULL_FAULT: assert property (@(posedge clk) disable iff (!rst_n) wr_en && fifo_full |=> fault) else $error("no fault"); // R6
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !wr_en) else $error("write in fault"); // R6
    AST_FAULT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !frame_start) else $error("frame in fault"); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fault && !(fault_clr && !run) |=> fault) else $error("fault lost"); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)) else $error("head moved"); // R8
endmodule

bind sample_logger slog_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .fault_clr(fault_clr), .fault(fault),
    .frame_start(frame_start), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_en(wr_en), .fifo_full(fifo_full), .rd_data(rd_data)
);

// File: tb/sample_logger_tb.sv
module sample_logger_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4, DW = 16, DEPTH = 8, CPU = 3, PER_W = 12;

    logic clk = 0, rst_n = 0, run = 0, fault_clr = 0, rd_ready = 0, hold = 1;
    logic [1:0] unit_sel = 0;
    logic [PER_W-1:0] period = 0;
    logic [NCH*DW-1:0] smp_data = '0;
    logic frame_start, fault, rd_valid;
    logic [DW-1:0] rd_data;

    int nchk = 0, nerr = 0, cyc = 0, seed = 1;
    logic [DW-1:0] exp_q[$];

    sample_logger #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .CLK_PER_US(CPU), .PER_W(PER_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .unit_sel(unit_sel), .period(period),
        .fault_clr(fault_clr), .smp_data(smp_data), .frame_start(frame_start),
        .fault(fault), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        rd_ready = hold ? 1'b0 : ((cyc % 3) != 2);
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    function automatic logic [NCH*DW-1:0] mk(input int s);
        logic [NCH*DW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*DW +: DW] = DW'((s << 4) ^ (c * 16'h0101) ^ 16'hA500);
        return v;
    endfunction

    // scoreboard monitor
    logic pv = 0, pr = 0;
    logic [DW-1:0] pd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr) chk(rd_valid && rd_data == pd, "R8 head held", rd_data, pd);
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", rd_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3 word order", rd_data, e);
                end
            end
        end
        pv = rd_valid; pr = rd_ready; pd = rd_data;
    end

    initial begin : watchdog
        wait (cyc > 150000);
        nchk++; nerr++;
        $display("FAIL watchdog act %0d exp 0", cyc);
        finish_run();
    end

    task automatic wait_frame();
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while (!frame_start && n < 10000);
        chk(frame_start, "R2 frame seen", frame_start, 1);
    endtask

    task automatic run_frames(input int nfr, input int spacing, input int wpf, input string tag);
        int last = 0;
        for (int i = 0; i <= nfr; i++) begin
            wait_frame();
            if (i > 0) chk(cyc - last == spacing, tag, cyc - last, spacing);
            last = cyc;
            if (i < nfr) for (int k = 0; k < wpf; k++) exp_q.push_back(smp_data[k*DW +: DW]);
            @(negedge clk);
            seed++; smp_data = mk(seed);
            if (i == nfr) run = 0;
        end
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0 && !rd_valid, "R3 drained", exp_q.size(), 0);
    endtask

    task automatic start(input logic [1:0] u, input int p);
        unit_sel = u; period = PER_W'(p); hold = 0;
        smp_data = mk(seed);
        @(negedge clk); run = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!rd_valid && !fault && !frame_start, "R1 reset state", {rd_valid, fault, frame_start}, 0);

        start(2'd0, 10); run_frames(4, 10, 4, "R2 tick spacing"); drain();
        start(2'd1, 4);  run_frames(3, 12, 4, "R2 us spacing"); drain();
        start(2'd2, 1);  run_frames(2, 3000, 4, "R2 ms spacing"); drain();
        start(2'd3, 6);  run_frames(3, 6, 4, "R2 tick alias spacing"); drain();
        start(2'd1, 0);  run_frames(3, 3, 3, "R4 period zero cut to 3"); drain();
        start(2'd0, 2);  run_frames(4, 2, 2, "R4 cut to 2"); drain();

        begin : idle_chk
            int fr = 0, wv = 0;
            run = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                fr += frame_start; wv += rd_valid;
            end
            chk(fr == 0 && wv == 0, "R5 idle no frame no write", fr + wv, 0);
        end

        begin : ovf_chk
            int fr = 0;
            unit_sel = 0; period = 20; smp_data = mk(seed); hold = 1;
            @(negedge clk); run = 1;
            for (int f = 0; f < 2; f++) begin
                wait_frame();
                for (int k = 0; k < NCH; k++) exp_q.push_back(smp_data[k*DW +: DW]);
                @(negedge clk); seed++; smp_data = mk(seed);
            end
            wait_frame();
            repeat (6) @(negedge clk);
            chk(fault, "R6 fault on overflow", fault, 1);
            for (int i = 0; i < 100; i++) begin @(negedge clk); fr += frame_start; end
            chk(fr == 0, "R6 no frames in fault", fr, 0);
            chk(rd_valid, "R8 data buffered", rd_valid, 1);
            fault_clr = 1; @(negedge clk); fault_clr = 0; @(negedge clk);
            chk(fault, "R7 clear ignored while run", fault, 1);
            hold = 0;
            drain();
            chk(fault, "R7 fault sticky after drain", fault, 1);
            run = 0; @(negedge clk);
            fault_clr = 1; @(negedge clk); fault_clr = 0; @(negedge clk);
            chk(!fault, "R7 clear while stopped", fault, 0);
        end

        start(2'd0, 10); run_frames(2, 10, 4, "R5 resume after clear"); drain();

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule